// File: doc/BRIEF.md
# Banked GPIO Controller with Edge Interrupts

This block controls a parameterised number of general-purpose pins. The pins are grouped into banks of 32. Each bank has seven word registers behind a synchronous read/write port: pin enable, output data, direction, sampled input level, interrupt mask, pending status and edge polarity. The block drives an output enable and an output level to every pad. It samples every pad input through a two-flop synchroniser.

A pin is driven only when it is enabled and its direction bit selects output. An enabled input pin records an edge of its chosen polarity as a pending bit. Software clears a pending bit by writing a zero to it. One combined interrupt line is raised while any pending bit is not masked.

When the pin count is not a multiple of 32, the last bank holds only the leftover pins. Its upper status bits stay at zero, and its other upper bits keep whatever value was written.

Top module: `gpio_bank_ctrl`

## Requirements
- R1: Pin n sits in bank n/32 at bit n%32. The word address is the register code shifted left by BANK_W bits, plus the bank index. BANK_W is the ceiling of log2 of the bank count, with a minimum of 1. The register codes are: 0 enable, 1 output data, 2 direction, 3 input level, 4 mask, 5 status, 6 edge polarity.
- R2: Reset clears enable, output data, edge polarity and status, and sets every direction bit and every mask bit to 1. After reset, pad_oe is all zero and irq is 0.
- R3: pad_oe[n] is 1 exactly when the enable bit is 1 and the direction bit is 0 (a direction bit of 1 means input). pad_out[n] follows the output data bit.
- R4: Input-level reads return the pad level after a two-flop synchroniser. A pad change is not visible to a read that samples on the second rising edge after the change, and is visible to the read after that.
- R5: When an enabled input pin has edge bit 1, a rising edge sets its status bit. When the edge bit is 0, a falling edge sets it.
- R6: An edge of the other polarity does not set the status bit. Neither does any edge on a disabled pin or on an output pin.
- R7: Writing the status register clears each bit written as 0 and leaves each bit written as 1 unchanged.
- R8: irq is the OR of all status bits whose mask bit is 0. Masking does not clear status.
- R9: In the last bank, status bits at or above the pin count never assert. The upper bits of the other writable registers store and return the written value.
- R10: Writes to register code 7, or to the input-level register, change nothing. A read of code 7 returns 0.
- R11: A read issued with rd_en returns its data on rdata after the next rising edge. rdata holds its value while rd_en is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 3+BANK_W | Word address {register code, bank index} |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, registered |
| pad_in | input | NUM_PINS | Pad input levels, asynchronous |
| pad_oe | output | NUM_PINS | Pad output enables |
| pad_out | output | NUM_PINS | Pad output levels |
| irq | output | 1 | Combined interrupt |

## Verification
Edge detection is tried with rising and falling pad transitions on four kinds of pin. The first is an enabled input with the matching polarity. The second is an enabled input with the opposite polarity. The third is a disabled pin, and the fourth is an enabled output pin. Only the first kind may set a status bit, so one wrongly gated term shows up as an extra pending bit.

Status writes with mixed zero and one bits tell clear-on-zero apart from plain storage. Mask changes made while status is pending separate the interrupt gating from the status itself. In the partial last bank, all-ones writes show that the upper bits are stored while their status bits stay zero. An edge placed just above a bank boundary checks the bank and bit mapping.

// File: rtl/gpio_pkg.sv
package gpio_pkg;

    localparam int BANK_BITS = 32;

    typedef enum logic [2:0] {
        REG_ENABLE = 3'd0,
        REG_WDATA  = 3'd1,
        REG_DIR    = 3'd2,
        REG_LEVEL  = 3'd3,
        REG_MASK   = 3'd4,
        REG_STATUS = 3'd5,
        REG_EDGE   = 3'd6,
        REG_NONE   = 3'd7
    } gpio_reg_e;

    typedef struct packed {
        logic enable;
        logic wdata;
        logic dir;
        logic mask;
        logic status;
        logic edgesel;
    } bank_wr_t;

    typedef struct packed {
        logic [BANK_BITS-1:0] enable;
        logic [BANK_BITS-1:0] wdata;
        logic [BANK_BITS-1:0] dir;
        logic [BANK_BITS-1:0] mask;
        logic [BANK_BITS-1:0] status;
        logic [BANK_BITS-1:0] edgesel;
        logic [BANK_BITS-1:0] level;
    } bank_view_t;

    function automatic logic [BANK_BITS-1:0] valid_mask(input int pins);
        logic [BANK_BITS-1:0] m;
        for (int i = 0; i < BANK_BITS; i++) begin
            m[i] = (i < pins);
        end
        return m;
    endfunction

endpackage

// File: rtl/gpio_sync_edge.sv
module gpio_sync_edge #(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] raw,
    output logic [WIDTH-1:0] level,
    output logic [WIDTH-1:0] rise,
    output logic [WIDTH-1:0] fall
);
    logic [WIDTH-1:0] stage1;
    logic [WIDTH-1:0] stage2;
    logic [WIDTH-1:0] prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage1 <= '0;
            stage2 <= '0;
            prev   <= '0;
        end else begin
            stage1 <= raw;
            stage2 <= stage1;
            prev   <= stage2;
        end
    end

    assign level = stage2;
    assign rise  = stage2 & ~prev;
    assign fall  = ~stage2 & prev;
endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
    import gpio_pkg::*;
#(
    parameter int VALID = 32
) (
    input  logic                 clk,
    input  logic                 rst,
    input  bank_wr_t             wr,
    input  logic [BANK_BITS-1:0] wdata,
    input  logic [BANK_BITS-1:0] pad,
    output bank_view_t           view,
    output logic [BANK_BITS-1:0] oe,
    output logic [BANK_BITS-1:0] out,
    output logic                 irq_req
);
    localparam logic [BANK_BITS-1:0] VMASK = valid_mask(VALID);

    logic [BANK_BITS-1:0] enable_q, wdata_q, dir_q, mask_q, status_q, edge_q;
    logic [BANK_BITS-1:0] level, rise, fall, hit;

    gpio_sync_edge #(.WIDTH(BANK_BITS)) u_sync (
        .clk   (clk),
        .rst   (rst),
        .raw   (pad),
        .level (level),
        .rise  (rise),
        .fall  (fall)
    );

    assign hit = enable_q & dir_q & VMASK & ((edge_q & rise) | (~edge_q & fall));

    always_ff @(posedge clk) begin
        if (rst) begin
            enable_q <= '0;
            wdata_q  <= '0;
            dir_q    <= '1;
            mask_q   <= '1;
            status_q <= '0;
            edge_q   <= '0;
        end else begin
            if (wr.enable)  enable_q <= wdata;
            if (wr.wdata)   wdata_q  <= wdata;
            if (wr.dir)     dir_q    <= wdata;
            if (wr.mask)    mask_q   <= wdata;
            if (wr.edgesel) edge_q   <= wdata;
            status_q <= (wr.status ? (status_q & wdata) : status_q) | hit;
        end
    end

    assign oe      = enable_q & ~dir_q & VMASK;
    assign out     = wdata_q & VMASK;
    assign irq_req = |(status_q & ~mask_q);

    always_comb begin
        view.enable  = enable_q;
        view.wdata   = wdata_q;
        view.dir     = dir_q;
        view.mask    = mask_q;
        view.status  = status_q;
        view.edgesel = edge_q;
        view.level   = level;
    end

    AST_STATUS_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
        (status_q & ~VMASK) == '0); // R9
    AST_SET_NEEDS_ENABLED_INPUT: assert property (@(posedge clk) disable iff (rst)
        !rst |=> ((status_q & ~$past(status_q)) & ~$past(enable_q & dir_q)) == '0); // R6
    AST_STATUS_CLEAR_ON_ZERO: assert property (@(posedge clk) disable iff (rst)
        wr.status |=> (status_q & ~$past(wdata) & ~$past(rise | fall)) == '0); // R7
endmodule

// File: rtl/gpio_bank_ctrl.sv
module gpio_bank_ctrl
    import gpio_pkg::*;
#(
    parameter int NUM_PINS = 40,
    localparam int NUM_BANKS = (NUM_PINS + BANK_BITS - 1) / BANK_BITS,
    localparam int BANK_W = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
    localparam int ADDR_W = 3 + BANK_W
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                wr_en,
    input  logic                rd_en,
    input  logic [ADDR_W-1:0]   addr,
    input  logic [31:0]         wdata,
    output logic [31:0]         rdata,
    input  logic [NUM_PINS-1:0] pad_in,
    output logic [NUM_PINS-1:0] pad_oe,
    output logic [NUM_PINS-1:0] pad_out,
    output logic                irq
);
    localparam int PAD_W = NUM_BANKS * BANK_BITS;

    gpio_reg_e         sel;
    logic [BANK_W-1:0] bank_idx;
    logic [PAD_W-1:0]  pad_wide, oe_wide, out_wide;
    logic [NUM_BANKS-1:0] irq_bank;
    bank_view_t        view [NUM_BANKS];
    logic [31:0]       rd_word;

    assign sel      = gpio_reg_e'(addr[ADDR_W-1:BANK_W]);
    assign bank_idx = addr[BANK_W-1:0];

    always_comb begin
        pad_wide = '0;
        pad_wide[NUM_PINS-1:0] = pad_in;
    end

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        localparam int VALID = (b == NUM_BANKS - 1) ? (NUM_PINS - b * BANK_BITS) : BANK_BITS;
        bank_wr_t wr_b;

        always_comb begin
            wr_b = '0;
            if (wr_en && bank_idx == BANK_W'(b)) begin
                case (sel)
                    REG_ENABLE: wr_b.enable  = 1'b1;
                    REG_WDATA:  wr_b.wdata   = 1'b1;
                    REG_DIR:    wr_b.dir     = 1'b1;
                    REG_MASK:   wr_b.mask    = 1'b1;
                    REG_STATUS: wr_b.status  = 1'b1;
                    REG_EDGE:   wr_b.edgesel = 1'b1;
                    default:    wr_b = '0;
                endcase
            end
        end

        gpio_bank #(.VALID(VALID)) u_bank (
            .clk     (clk),
            .rst     (rst),
            .wr      (wr_b),
            .wdata   (wdata),
            .pad     (pad_wide[b*BANK_BITS +: BANK_BITS]),
            .view    (view[b]),
            .oe      (oe_wide[b*BANK_BITS +: BANK_BITS]),
            .out     (out_wide[b*BANK_BITS +: BANK_BITS]),
            .irq_req (irq_bank[b])
        );
    end

    always_comb begin
        rd_word = '0;
        for (int b = 0; b < NUM_BANKS; b++) begin
            if (bank_idx == BANK_W'(b)) begin
                case (sel)
                    REG_ENABLE: rd_word = view[b].enable;
                    REG_WDATA:  rd_word = view[b].wdata;
                    REG_DIR:    rd_word = view[b].dir;
                    REG_LEVEL:  rd_word = view[b].level;
                    REG_MASK:   rd_word = view[b].mask;
                    REG_STATUS: rd_word = view[b].status;
                    REG_EDGE:   rd_word = view[b].edgesel;
                    default:    rd_word = '0;
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst)        rdata <= '0;
        else if (rd_en) rdata <= rd_word;
    end

    assign pad_oe  = oe_wide[NUM_PINS-1:0];
    assign pad_out = out_wide[NUM_PINS-1:0];
    assign irq     = |irq_bank;

    AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (rst)
        !rd_en |=> $stable(rdata)); // R11
    AST_RESET_QUIET: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (pad_oe == '0 && !irq)); // R2
endmodule

// File: tb/sim_gpio_bank_ctrl.sv
module sim_gpio_bank_ctrl;
    localparam int NP = 40;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [3:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [NP-1:0] pads = '0;
    logic [NP-1:0] pad_oe, pad_out;
    logic        irq;

    int total = 0;
    int bad = 0;
    bit done = 0;
    logic rd_seen = 1'b0;
    logic [31:0] exp_q[$];
    string       tag_q[$];

    always #10 clk = ~clk;

    gpio_bank_ctrl #(.NUM_PINS(NP)) u0 (
        .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .pad_in(pads), .pad_oe(pad_oe),
        .pad_out(pad_out), .irq(irq)
    );

    // register codes: 0 enable,1 wdata,2 dir,3 level,4 mask,5 status,6 edge; BANK_W=1
    function automatic logic [3:0] ra(input int code, input int bank);
        return 4'(code * 2 + bank);
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, input logic [31:0] exp, input string tag);
        @(negedge clk);
        rd_en = 1'b1; addr = a;
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // scoreboard monitor: R11 one-cycle read latency
    always @(posedge clk) rd_seen <= rd_en;

    always @(negedge clk) begin
        if (rd_seen) begin
            if (exp_q.size() == 0) begin
                total++; bad++;
                $display("FAIL R11 unexpected read act=%h exp=none", rdata);
            end else begin
                chk(tag_q.pop_front(), rdata, exp_q.pop_front());
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R2 pad_oe after reset", 32'(pad_oe), 32'h0);
        chk("R2 irq after reset", 32'(irq), 32'h0);
        rd(ra(2,0), 32'hFFFF_FFFF, "R2 dir bank0");
        rd(ra(2,1), 32'hFFFF_FFFF, "R2 dir bank1");
        rd(ra(4,0), 32'hFFFF_FFFF, "R2 mask bank0");
        rd(ra(0,0), 32'h0, "R2 enable bank0");
        rd(ra(5,0), 32'h0, "R2 status bank0");
        rd(ra(6,1), 32'h0, "R2 edge bank1");
        rd(ra(1,0), 32'h0, "R2 wdata bank0");

        // R3 output pin 0
        wr(ra(2,0), 32'hFFFF_FFFE);
        wr(ra(1,0), 32'h0000_0001);
        chk("R3 oe off while disabled", 32'(pad_oe), 32'h0);
        chk("R3 pad_out follows wdata", 32'(pad_out), 32'h1);
        wr(ra(0,0), 32'h0000_004F);
        chk("R3 oe on enabled output only", 32'(pad_oe), 32'h1);

        // R1 / R4 bank mapping and synchroniser
        @(negedge clk);
        pads[33] = 1'b1; pads[5] = 1'b1;
        idle(3);
        rd(ra(3,1), 32'h0000_0002, "R1 pin33 in bank1 bit1");
        rd(ra(3,0), 32'h0000_0020, "R1 pin5 in bank0 bit5");
        pads[7] = 1'b1;
        rd(ra(3,0), 32'h0000_0020, "R4 two-flop delay hides new level");
        rd(ra(3,0), 32'h0000_00A0, "R4 level visible next read");

        // edge setup: pins 2,4 rising; 3,6 falling; unmask 2,3
        wr(ra(6,0), 32'h0000_0014);
        wr(ra(4,0), 32'hFFFF_FFF3);
        @(negedge clk); pads[2] = 1'b1;
        idle(4);
        rd(ra(5,0), 32'h0000_0004, "R5 rising edge sets status");
        chk("R8 irq with unmasked pending", 32'(irq), 32'h1);

        @(negedge clk); pads[3] = 1'b1; pads[4] = 1'b1; pads[6] = 1'b1;
        idle(4);
        @(negedge clk); pads[0] = 1'b1;
        idle(4);
        @(negedge clk); pads[0] = 1'b0;
        idle(4);
        rd(ra(5,0), 32'h0000_0004, "R6 wrong polarity, disabled, output pins ignored");

        @(negedge clk); pads[3] = 1'b0;
        idle(4);
        rd(ra(5,0), 32'h0000_000C, "R5 falling edge sets status");

        wr(ra(4,0), 32'hFFFF_FFFF);
        chk("R8 irq low when all masked", 32'(irq), 32'h0);
        rd(ra(5,0), 32'h0000_000C, "R8 mask keeps status");
        wr(ra(4,0), 32'hFFFF_FFF7);
        chk("R8 irq from pin3 unmasked", 32'(irq), 32'h1);

        wr(ra(5,0), 32'hFFFF_FFF7);
        rd(ra(5,0), 32'h0000_0004, "R7 zero clears one keeps");
        chk("R8 irq after clear of unmasked bit", 32'(irq), 32'h0);
        wr(ra(5,0), 32'h0);
        rd(ra(5,0), 32'h0, "R7 all cleared");

        // R9 partial last bank
        wr(ra(0,1), 32'hFFFF_FFFF);
        wr(ra(6,1), 32'hFFFF_FFFF);
        wr(ra(4,1), 32'h0);
        wr(ra(1,1), 32'hA5A5_0000);
        rd(ra(0,1), 32'hFFFF_FFFF, "R9 upper enable bits stored");
        rd(ra(1,1), 32'hA5A5_0000, "R9 upper wdata bits stored");
        wr(ra(5,1), 32'hFFFF_FFFF);
        rd(ra(5,1), 32'h0, "R9 status not set by write");
        @(negedge clk); pads[39] = 1'b1;
        idle(4);
        rd(ra(5,1), 32'h0000_0080, "R9 only valid status bit set");
        chk("R8 irq from bank1", 32'(irq), 32'h1);
        wr(ra(5,1), 32'h0);
        chk("R7 bank1 clear drops irq", 32'(irq), 32'h0);

        // R10 unmapped and read-only writes
        wr(ra(7,0), 32'h0);
        wr(ra(3,0), 32'h0);
        rd(ra(0,0), 32'h0000_004F, "R10 code7 write ignored");
        rd(ra(3,0), pads[31:0], "R10 level write ignored");
        rd(ra(7,1), 32'h0, "R10 code7 reads zero");

        idle(3);
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog R11 act=hung exp=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule